// File: doc/BRIEF.md
# Pipe Buffer-Ready Interrupt Controller

This block keeps one buffer-ready status bit for each of eight endpoint pipes and merges them into a single registered interrupt line. Each cycle the packet engine reports events for every pipe: a short packet received, a zero-length packet received, a buffer filled, a transaction count reached, or a transmit buffer that can be written again after a packet was sent and acknowledged. A per-pipe direction bit chooses which events count. On receive pipes 1 to 7, a per-pipe transfer-end bit limits setting to the end of a transfer, so a filled buffer does not interrupt. Pipe 0 always interrupts per packet.

Software reads the status vector and clears bits by writing zeros. A zero-length packet sets its status bit even though no data can be read. Software is expected to clear that status bit before it flushes the pipe buffer. The summary line has two release policies, picked by a global mode input. In mode 0 it follows the enabled status bits. In mode 1 it is held until the FIFO's buffer-ready flags of every enabled pipe have dropped.

Top module: `pipe_rdy_irq`

## Requirements
- R1: While reset is asserted and on the first cycles after it, `status_o` is all zeros and `irq_o` is 0.
- R2: On a receive pipe (`pipe_tx_i` bit = 0) with its transfer-end bit at 0, any of short packet, zero-length packet, full buffer or transaction count sets that pipe's status bit on the next clock edge.
- R3: On a receive pipe numbered 1 to 7 with its transfer-end bit at 1, a full-buffer event alone leaves the status bit unchanged. Short packet, zero-length packet and transaction count still set it.
- R4: Pipe 0 ignores its transfer-end bit, so a full-buffer event always sets its status bit.
- R5: On a transmit pipe (`pipe_tx_i` bit = 1), only the sent-and-writable event sets the status bit, and receive events are ignored. On a receive pipe, the sent-and-writable event is ignored.
- R6: When `sw_wr_i` is 1, each status bit whose `sw_wdata_i` bit is 0 is cleared on the next edge, and bits written with 1 keep their value. Without a write or an event, the status is held.
- R7: If a set event and a software clear hit the same bit in the same cycle, the bit ends up set.
- R8: In mode 0 (`hw_release_i` = 0), `irq_o` in a cycle equals the OR of `status_o & pipe_en_i` from the cycle before.
- R9: In mode 1, `irq_o` rises on the edge after a set event on an enabled pipe. It stays high while any enabled pipe's `buf_rdy_i` bit is 1, and clearing status by software does not release it. It falls on the edge after a cycle in which no enabled pipe has `buf_rdy_i` set and no enabled pipe has a set event.
- R10: Clearing a pipe's enable bit removes that pipe from the summary but keeps its stored status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ev_short_i | input | 8 | Short data packet received, per pipe |
| ev_zlp_i | input | 8 | Zero-length packet received, per pipe |
| ev_full_i | input | 8 | Receive buffer became full, per pipe |
| ev_tcnt_i | input | 8 | Transaction count reached, per pipe |
| ev_txdone_i | input | 8 | Packet sent and acknowledged, buffer writable again, per pipe |
| pipe_tx_i | input | 8 | Pipe direction, 1 = transmit |
| pipe_xend_i | input | 8 | Transfer-end mode per pipe (bit 0 has no effect) |
| pipe_en_i | input | 8 | Interrupt enable mask per pipe |
| hw_release_i | input | 1 | Summary release policy: 0 = software status clear, 1 = buffer drain |
| buf_rdy_i | input | 8 | Buffer-ready flags from the FIFO logic, per pipe |
| sw_wr_i | input | 1 | Status register write strobe |
| sw_wdata_i | input | 8 | Status write data, 0 clears a bit and 1 keeps it |
| status_o | output | 8 | Buffer-ready status vector |
| irq_o | output | 1 | Registered summary interrupt |

## Verification
The bench sends a full-buffer event to a pipe in transfer-end mode. A design that applied per-packet rules there would set the status bit. It sends the same event to pipe 0 in that mode, which a design that ignored the pipe-0 exception would drop. A sent event on a receive pipe and receive events on a transmit pipe must change nothing. A software clear that lands in the same cycle as a set must leave the bit set, or an event is lost. In mode 1 the bench clears status while a buffer flag is still high, and a design that released on the software clear would drop the line early. It also disables a pipe that has status stored, and a design that wiped the stored bit would show it on `status_o`.

// File: rtl/rdy_pkg.sv
package rdy_pkg;
  localparam int unsigned PIPES = 8;

  typedef struct packed {
    logic short_pkt;
    logic zlp;
    logic full;
    logic tcnt;
    logic tx_done;
  } pipe_evt_t;
endpackage

// File: rtl/rdy_evt_decode.sv
module rdy_evt_decode
  import rdy_pkg::*;
#(
  parameter int unsigned PIPE_IDX = 0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  pipe_evt_t evt_i,
  input  logic      is_tx_i,
  input  logic      xend_i,
  output logic      set_o
);
  localparam bit XEND_OK = (PIPE_IDX != 0);

  logic rx_any;
  logic rx_end;

  always_comb begin
    rx_any = evt_i.short_pkt | evt_i.zlp | evt_i.full | evt_i.tcnt;
    rx_end = evt_i.short_pkt | evt_i.zlp | evt_i.tcnt;
    if (is_tx_i)                set_o = evt_i.tx_done;
    else if (xend_i && XEND_OK) set_o = rx_end;
    else                        set_o = rx_any;
  end

  // R3
  xend_full_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_tx_i && xend_i && XEND_OK && evt_i.full &&
     !evt_i.short_pkt && !evt_i.zlp && !evt_i.tcnt) |-> !set_o);

  // R5
  tx_ignores_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_tx_i && !evt_i.tx_done) |-> !set_o);

  // R5
  rx_ignores_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_tx_i && evt_i.tx_done && !evt_i.short_pkt && !evt_i.zlp &&
     !evt_i.full && !evt_i.tcnt) |-> !set_o);

  generate
    if (PIPE_IDX == 0) begin : g_pipe0
      // R4
      pipe0_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_tx_i && evt_i.full) |-> set_o);
    end
  endgenerate
endmodule

// File: rtl/rdy_status_bank.sv
module rdy_status_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] stat_q;
  logic [N-1:0] stat_d;
  logic         stat_en;

  always_comb begin
    stat_en = wr_i | (|set_i);
    stat_d  = stat_q;
    if (wr_i) stat_d = stat_d & wdata_i;
    stat_d = stat_d | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign status_o = stat_q;

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((stat_q & $past(set_i)) == $past(set_i)));

  // R6
  wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && set_i == '0) |=> ((stat_q & ~$past(wdata_i)) == '0));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && set_i == '0) |=> $stable(stat_q));
endmodule

// File: rtl/rdy_summary.sv
module rdy_summary #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] status_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] buf_rdy_i,
  input  logic         hw_mode_i,
  output logic         irq_o
);
  logic irq_q;
  logic irq_d;
  logic any_stat;
  logic any_set;
  logic any_buf;

  always_comb begin
    any_stat = |(status_i & en_i);
    any_set  = |(set_i & en_i);
    any_buf  = |(buf_rdy_i & en_i);
    if (hw_mode_i) irq_d = any_set | (irq_q & any_buf);
    else           irq_d = any_stat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R8
  mode0_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_mode_i && (|(status_i & en_i))) |=> irq_o);

  // R8
  mode0_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_mode_i && !(|(status_i & en_i))) |=> !irq_o);

  // R9
  mode1_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_mode_i && (|(set_i & en_i))) |=> irq_o);

  // R9
  mode1_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_mode_i && !(|(set_i & en_i)) && !(|(buf_rdy_i & en_i))) |=> !irq_o);

  // R9
  mode1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_mode_i && irq_o && (|(buf_rdy_i & en_i))) |=> irq_o);
endmodule

// File: rtl/pipe_rdy_irq.sv
module pipe_rdy_irq
  import rdy_pkg::*;
#(
  parameter int unsigned N = PIPES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_short_i,
  input  logic [N-1:0] ev_zlp_i,
  input  logic [N-1:0] ev_full_i,
  input  logic [N-1:0] ev_tcnt_i,
  input  logic [N-1:0] ev_txdone_i,
  input  logic [N-1:0] pipe_tx_i,
  input  logic [N-1:0] pipe_xend_i,
  input  logic [N-1:0] pipe_en_i,
  input  logic         hw_release_i,
  input  logic [N-1:0] buf_rdy_i,
  input  logic         sw_wr_i,
  input  logic [N-1:0] sw_wdata_i,
  output logic [N-1:0] status_o,
  output logic         irq_o
);
  logic [1:0]   rst_sync_q;
  logic         rst_int_n;
  logic [N-1:0] set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  generate
    for (genvar p = 0; p < N; p++) begin : g_pipe
      pipe_evt_t evt;
      always_comb begin
        evt.short_pkt = ev_short_i[p];
        evt.zlp       = ev_zlp_i[p];
        evt.full      = ev_full_i[p];
        evt.tcnt      = ev_tcnt_i[p];
        evt.tx_done   = ev_txdone_i[p];
      end
      rdy_evt_decode #(.PIPE_IDX(p)) u_dec (
        .clk     (clk),
        .rst_n   (rst_int_n),
        .evt_i   (evt),
        .is_tx_i (pipe_tx_i[p]),
        .xend_i  (pipe_xend_i[p]),
        .set_o   (set_vec[p])
      );
    end
  endgenerate

  rdy_status_bank #(.N(N)) u_bank (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .set_i    (set_vec),
    .wr_i     (sw_wr_i),
    .wdata_i  (sw_wdata_i),
    .status_o (status_o)
  );

  rdy_summary #(.N(N)) u_sum (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .status_i  (status_o),
    .set_i     (set_vec),
    .en_i      (pipe_en_i),
    .buf_rdy_i (buf_rdy_i),
    .hw_mode_i (hw_release_i),
    .irq_o     (irq_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_int_n |-> (status_o == '0 && !irq_o));

  // R10
  disable_keeps_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!sw_wr_i && $fell(pipe_en_i[0])) |-> status_o[0] == $past(status_o[0]));
endmodule

// File: tb/sim_pipe_rdy_irq.sv
module sim_pipe_rdy_irq;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] e_short = '0, e_zlp = '0, e_full = '0, e_tcnt = '0, e_txd = '0;
  logic [N-1:0] dir_tx = '0, xend = '0, en = '0, bufrdy = '0, wdata = '0;
  logic         wr = 1'b0, mode = 1'b0;
  logic [N-1:0] status;
  logic         irq;

  logic [N-1:0] m_stat = '0;
  logic         m_irq = 1'b0;
  logic [N-1:0] q_stat[$];
  logic         q_irq[$];
  string        q_tag[$];
  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe_rdy_irq u0 (
    .clk(clk), .rst_n(rst_n),
    .ev_short_i(e_short), .ev_zlp_i(e_zlp), .ev_full_i(e_full),
    .ev_tcnt_i(e_tcnt), .ev_txdone_i(e_txd),
    .pipe_tx_i(dir_tx), .pipe_xend_i(xend), .pipe_en_i(en),
    .hw_release_i(mode), .buf_rdy_i(bufrdy),
    .sw_wr_i(wr), .sw_wdata_i(wdata),
    .status_o(status), .irq_o(irq)
  );

  // expected set vector derived from R2..R5
  function automatic logic [N-1:0] exp_set();
    logic [N-1:0] s;
    for (int p = 0; p < N; p++) begin
      if (dir_tx[p])              s[p] = e_txd[p];
      else if (xend[p] && p != 0) s[p] = e_short[p] | e_zlp[p] | e_tcnt[p];
      else                        s[p] = e_short[p] | e_zlp[p] | e_full[p] | e_tcnt[p];
    end
    return s;
  endfunction

  // driver: one clock, update the model, push the expectation
  task automatic step(input string tag);
    logic [N-1:0] s;
    logic         ni;
    @(posedge clk);
    s = exp_set();
    if (mode) ni = (|(s & en)) | (m_irq & (|(bufrdy & en)));
    else      ni = |(m_stat & en);
    m_stat = (wr ? (m_stat & wdata) : m_stat) | s;
    m_irq  = ni;
    q_stat.push_back(m_stat);
    q_irq.push_back(m_irq);
    q_tag.push_back(tag);
    @(negedge clk);
    #1;
    e_short = '0; e_zlp = '0; e_full = '0; e_tcnt = '0; e_txd = '0; wr = 1'b0;
  endtask

  // monitor: compare results against the queue
  always @(negedge clk) begin
    if (q_tag.size() > 0) begin
      logic [N-1:0] es;
      logic         ei;
      string        t;
      es = q_stat.pop_front();
      ei = q_irq.pop_front();
      t  = q_tag.pop_front();
      checks++;
      if (status !== es || irq !== ei) begin
        fails++;
        $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b", t, status, irq, es, ei);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (status !== '0 || irq !== 1'b0) begin
      fails++;
      $display("FAIL R1 in reset: status=%h irq=%b expected 00 0", status, irq);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    dir_tx = 8'hF0; en = 8'hFF;
    step("R1 after reset");

    // R2 per-packet receive events
    e_short[1] = 1'b1; step("R2 short pipe1");
    step("R8 irq follows status");
    e_zlp[2] = 1'b1; e_full[3] = 1'b1; e_tcnt[0] = 1'b1; step("R2 zlp/full/tcnt");
    wr = 1'b1; wdata = 8'h00; step("R6 clear all");
    step("R8 irq drops after clear");

    // R3/R4 transfer-end mode
    xend = 8'h0F;
    e_full[0] = 1'b1; e_full[1] = 1'b1; e_full[2] = 1'b1; step("R3 R4 full in xend mode");
    e_short[1] = 1'b1; e_tcnt[2] = 1'b1; e_zlp[3] = 1'b1; step("R3 end-of-transfer sets");
    wr = 1'b1; wdata = 8'hFF; step("R6 write ones keeps");
    wr = 1'b1; wdata = 8'hF1; step("R6 partial clear");

    // R5 direction filtering
    e_txd[5] = 1'b1; e_full[6] = 1'b1; e_short[7] = 1'b1; e_txd[2] = 1'b1; step("R5 tx filter");
    // R7 set beats clear
    e_txd[5] = 1'b1; e_txd[4] = 1'b1; wr = 1'b1; wdata = 8'h0F; step("R7 set wins");

    // R10 disable keeps stored status
    en = 8'h00; step("R10 disable");
    step("R10 irq masked, status kept");
    en = 8'h10; step("R8 single enable");
    step("R8 irq from pipe4");
    en = 8'hFF; wr = 1'b1; wdata = 8'h00; step("R6 clear before mode1");
    step("R8 settle");

    // R9 buffer-drain release
    mode = 1'b1; bufrdy = 8'h02;
    e_short[1] = 1'b1; step("R9 raise");
    wr = 1'b1; wdata = 8'h00; step("R9 sw clear does not release");
    step("R9 hold while buffer ready");
    bufrdy = 8'h80; en = 8'h7F; step("R9 disabled buffer ignored");
    step("R9 released");
    en = 8'hFF; bufrdy = 8'h00; e_txd[6] = 1'b1; step("R9 raise tx pipe");
    step("R9 drop without buffer flag");
    e_full[3] = 1'b1; en = 8'hF7; step("R9 disabled pipe event no raise");

    step("drain");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule